// File: doc/BRIEF.md
# Accelerator Revolution Clock Generator

This block produces the machine timing strobes of a two-ring accelerator from one event clock, which is the RF master divided by four (about 124.9 MHz, about 8 ns per cycle). Three free-running modulo counters share that clock. One gives the booster revolution strobe (divide by 207). One gives the storage ring revolution strobe (divide by 216). The third gives the coincidence strobe (divide by 4968, which is 24 booster turns and 23 storage ring turns). A global sync input restarts all three counters together, so the booster and storage ring strobes always fall on every coincidence strobe.

A 60 Hz mains reference enters asynchronously. It is synchronised, edge-detected and divided by a programmable ratio from 1 to 256, which sets the injection repetition rate (for example 20, 24, 30, 40 or 60 give 3, 2.5, 2, 1.5 or 1 Hz). Each divided mains pulse is held until the next coincidence strobe. It is then released after a programmable phase delay of 0 to 25.5 ms, set in 0.1 ms steps.

All four strobes are one event-clock cycle wide and serve as trigger-event requests. A per-strobe enable bit copies each strobe onto its own distributed-bus bit.

Top module: `rev_clock_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every strobe and every bus bit is 0 after that edge.
- R2: Counting edges from the last reset or sync edge as k (that edge being k=0), `br_tick_o` is high after edge k exactly when k>0 and k is a multiple of BR_DIV.
- R3: Under the same counting, `sr_tick_o` is high exactly when k>0 and k is a multiple of SR_DIV.
- R4: Under the same counting, `coinc_tick_o` is high exactly when k>0 and k is a multiple of COINC_DIV. Whenever it is high, both revolution strobes are high too.
- R5: A clock edge that samples `sync_i` high clears all three counters together and suppresses their strobes after that edge, so counting restarts from k=0.
- R6: Rising edges of `mains_i` are synchronised and counted. Every Nth rising edge makes one injection request, where N equals `mains_div_i` and the value 0 means 256. Fewer than N edges give no `rep_tick_o` pulse.
- R7: An injection request is held and released only on a coincidence strobe. The request is pending from the fourth edge after the edge that first samples the mains rise. With a phase setting of 0, `rep_tick_o` rises together with the first `coinc_tick_o` at or after that edge.
- R8: With phase setting P (`phase_i`, 8 bits, one step equal to STEP_CYC event clocks), `rep_tick_o` pulses for one cycle exactly P*STEP_CYC cycles after the releasing coincidence strobe.
- R9: Bus bit i equals strobe i AND `dbus_en_i[i]`. The bit order is 0 booster, 1 storage ring, 2 coincidence, 3 repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Restarts the three revolution counters together |
| mains_i | input | 1 | Asynchronous mains reference |
| mains_div_i | input | 8 | Mains divide ratio, 0 means 256 |
| phase_i | input | 8 | Phase delay in steps of STEP_CYC event clocks |
| dbus_en_i | input | 4 | Per-strobe distributed-bus enable |
| br_tick_o | output | 1 | Booster revolution strobe |
| sr_tick_o | output | 1 | Storage ring revolution strobe |
| coinc_tick_o | output | 1 | Coincidence strobe |
| rep_tick_o | output | 1 | Delayed injection repetition strobe |
| dbus_o | output | 4 | Distributed-bus bits |

## Verification
The bench runs a small configuration with ratios 3, 4 and 12 and a step of two cycles. It predicts every strobe in every cycle from the edge count since the last reset or sync. A counter that is off by one drifts away from the prediction, and a sync that restarts only some counters breaks the coincidence alignment. The mains sweep uses ratios 1, 2, 5 and 0 (256) and phase settings from 0 to 255. It checks that one edge short of the ratio gives nothing, and that the request leaves on the first coincidence strobe after it becomes pending. A divider that treats 0 as zero, or a release that ignores the coincidence strobe, puts the repetition pulse in the wrong cycle or leaves it out. A phase counter that loads P*STEP instead of P*STEP-1 shows up as a one-cycle shift.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int NSTRB    = 4;
  localparam int IDX_BR   = 0;
  localparam int IDX_SR   = 1;
  localparam int IDX_COIN = 2;
  localparam int IDX_REP  = 3;
  localparam int NDIV     = 3;
endpackage

// File: rtl/rcg_divider.sv
module rcg_divider #(
  parameter int DIV = 207
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic tick_o,
  output logic wrap_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  // wrap_o: the coming edge makes tick_o high
  assign wrap_o = (cnt_q == LAST) && !sync_i;

  always_ff @(posedge clk) begin
    if (rst || sync_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      tick_o <= (cnt_q == LAST);
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_tick_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (cnt_q == '0));
  p_sync_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> !tick_o);
endmodule

// File: rtl/rcg_mains_div.sv
module rcg_mains_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mains_i,
  input  logic [DW-1:0] div_i,
  output logic          pulse_o
);
  logic          s1_q, s2_q, s3_q;
  logic          rise;
  logic [DW:0]   lim;
  logic [DW-1:0] cnt_q;

  assign rise = s2_q && !s3_q;
  assign lim  = (div_i == '0) ? (DW+1)'(1 << DW) : {1'b0, div_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      s1_q    <= mains_i;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      pulse_o <= 1'b0;
      if (rise) begin
        if ({1'b0, cnt_q} >= lim - 1'b1) begin
          cnt_q   <= '0;
          pulse_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_pulse_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(rise));
  p_cnt_below_lim_r6: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt_q} < lim || !$stable(div_i));
endmodule

// File: rtl/rcg_phase_delay.sv
module rcg_phase_delay #(
  parameter int STEP_CYC = 12491,
  parameter int PW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          coinc_wrap_i,
  input  logic [PW-1:0] phase_i,
  output logic          fire_o
);
  localparam int SW = $clog2(STEP_CYC + 1);
  localparam int DW = PW + SW;

  logic          pending_q, active_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] dly;
  logic          release_now;

  assign dly         = DW'(phase_i) * DW'(STEP_CYC);
  assign release_now = pending_q && coinc_wrap_i && !active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      fire_o    <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (release_now) begin
        pending_q <= req_i;
        if (dly == '0) begin
          fire_o <= 1'b1;
        end else begin
          active_q <= 1'b1;
          cnt_q    <= dly - 1'b1;
        end
      end else begin
        if (req_i) pending_q <= 1'b1;
        if (active_q) begin
          if (cnt_q == '0) begin
            active_q <= 1'b0;
            fire_o   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  p_fire_source_r8: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> ($past(active_q) || $past(release_now)));
  p_fire_single_r8: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o || $past(release_now));
endmodule

// File: rtl/rev_clock_gen.sv
module rev_clock_gen #(
  parameter int BR_DIV    = 207,
  parameter int SR_DIV    = 216,
  parameter int COINC_DIV = 4968,
  parameter int STEP_CYC  = 12491,
  parameter int MDIV_W    = 8,
  parameter int PHASE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sync_i,
  input  logic                       mains_i,
  input  logic [MDIV_W-1:0]          mains_div_i,
  input  logic [PHASE_W-1:0]         phase_i,
  input  logic [rcg_pkg::NSTRB-1:0]  dbus_en_i,
  output logic                       br_tick_o,
  output logic                       sr_tick_o,
  output logic                       coinc_tick_o,
  output logic                       rep_tick_o,
  output logic [rcg_pkg::NSTRB-1:0]  dbus_o
);
  import rcg_pkg::*;

  logic [NDIV-1:0]  tick, wrap;
  logic             mains_pulse;
  logic             rep;
  logic [NSTRB-1:0] strb;

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    localparam int D = (g == IDX_BR) ? BR_DIV : (g == IDX_SR) ? SR_DIV : COINC_DIV;
    rcg_divider #(.DIV(D)) u_div (
      .clk    (clk),
      .rst    (rst),
      .sync_i (sync_i),
      .tick_o (tick[g]),
      .wrap_o (wrap[g])
    );
  end

  rcg_mains_div #(.DW(MDIV_W)) u_mains (
    .clk     (clk),
    .rst     (rst),
    .mains_i (mains_i),
    .div_i   (mains_div_i),
    .pulse_o (mains_pulse)
  );

  rcg_phase_delay #(.STEP_CYC(STEP_CYC), .PW(PHASE_W)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .req_i        (mains_pulse),
    .coinc_wrap_i (wrap[IDX_COIN]),
    .phase_i      (phase_i),
    .fire_o       (rep)
  );

  assign strb = {rep, tick[IDX_COIN], tick[IDX_SR], tick[IDX_BR]};

  for (genvar i = 0; i < NSTRB; i++) begin : g_bus
    assign dbus_o[i] = strb[i] & dbus_en_i[i];
  end

  assign br_tick_o    = tick[IDX_BR];
  assign sr_tick_o    = tick[IDX_SR];
  assign coinc_tick_o = tick[IDX_COIN];
  assign rep_tick_o   = rep;

  p_coinc_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    coinc_tick_o |-> (br_tick_o && sr_tick_o));
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (strb == '0));
endmodule

// File: tb/tb_rev_clock_gen.sv
module tb_rev_clock_gen;
  localparam int BR = 3, SR = 4, CO = 12, STEP = 2;
  localparam time HALF = 10ns;

  logic       clk = 0, rst = 1, sync_i = 0, mains_i = 0;
  logic [7:0] mains_div_i = 8'd1, phase_i = 8'd0;
  logic [3:0] dbus_en_i = 4'hF;
  logic br_tick_o, sr_tick_o, coinc_tick_o, rep_tick_o;
  logic [3:0] dbus_o;

  rev_clock_gen #(.BR_DIV(BR), .SR_DIV(SR), .COINC_DIV(CO), .STEP_CYC(STEP)) dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .mains_i(mains_i),
    .mains_div_i(mains_div_i), .phase_i(phase_i), .dbus_en_i(dbus_en_i),
    .br_tick_o(br_tick_o), .sr_tick_o(sr_tick_o), .coinc_tick_o(coinc_tick_o),
    .rep_tick_o(rep_tick_o), .dbus_o(dbus_o));

  always #HALF clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, base = 0, last_rise = 0, rep_cnt = 0, rep_at = -1, wd = 0;
  logic mains_prev = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // spec-side edge bookkeeping
  always @(posedge clk) begin
    if (rst) begin cyc = 0; base = 0; end
    else begin
      cyc = cyc + 1;
      if (sync_i) base = cyc;
      if (mains_i && !mains_prev) last_rise = cyc;
    end
    mains_prev = mains_i;
  end

  // per-cycle checker, sampled a quarter period after the edge
  always @(posedge clk) begin
    #(HALF/2);
    if (rst) begin
      chk({br_tick_o, sr_tick_o, coinc_tick_o, rep_tick_o} == 4'b0, "R1 strobes", 1, 0);
      chk(dbus_o == 4'b0, "R1 dbus", int'(dbus_o), 0);
    end else begin
      int k;
      bit eb, es, ec;
      k  = cyc - base;
      eb = (k > 0) && (k % BR == 0);
      es = (k > 0) && (k % SR == 0);
      ec = (k > 0) && (k % CO == 0);
      chk(br_tick_o == eb, "R2 br", int'(br_tick_o), int'(eb));
      chk(sr_tick_o == es, "R3 sr", int'(sr_tick_o), int'(es));
      chk(coinc_tick_o == ec, "R4 coinc", int'(coinc_tick_o), int'(ec));
      if (sync_i === 1'b0 && k == 0 && cyc > 0)
        chk(!br_tick_o && !sr_tick_o && !coinc_tick_o, "R5 sync", 1, 0);
      chk(dbus_o == ({rep_tick_o, ec, es, eb} & dbus_en_i), "R9 dbus",
          int'(dbus_o), int'({rep_tick_o, ec, es, eb} & dbus_en_i));
      if (rep_tick_o) begin rep_cnt++; rep_at = cyc; end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset(input logic [7:0] div, input logic [7:0] ph, input logic [3:0] en);
    @(negedge clk);
    rst = 1; mains_i = 0; sync_i = 0;
    mains_div_i = div; phase_i = ph; dbus_en_i = en;
    repeat (3) @(negedge clk);
    rst = 0;
    rep_cnt = 0; rep_at = -1;
  endtask

  task automatic one_rise();
    mains_i = 1;
    repeat (3) @(negedge clk);
    mains_i = 0;
    repeat (3) @(negedge clk);
  endtask

  // N rises, expect nothing after N-1, then exactly one pulse at the predicted edge
  task automatic mains_case(input int n, input logic [7:0] ph);
    int eff, w, r;
    eff = (n == 0) ? 256 : n;
    do_reset(8'(n), ph, 4'b1000);
    repeat (eff - 1) one_rise();
    repeat (40) @(negedge clk);
    chk(rep_cnt == 0, "R6 below ratio", rep_cnt, 0);
    mains_i = 1;
    @(negedge clk);
    repeat (2) @(negedge clk);
    mains_i = 0;
    w = ((last_rise + 4 + CO - 1) / CO) * CO;
    r = w + int'(ph) * STEP;
    while (cyc < r + 30) @(negedge clk);
    chk(rep_cnt == 1, "R6 one request", rep_cnt, 1);
    if (ph == 0) chk(rep_at == r, "R7 release on coinc", rep_at, r);
    else         chk(rep_at == r, "R8 phase delay", rep_at, r);
  endtask

  initial begin
    // periodic strobes with several bus masks
    do_reset(8'd1, 8'd0, 4'hF);
    repeat (60) @(negedge clk);
    do_reset(8'd1, 8'd0, 4'b0101);
    repeat (50) @(negedge clk);
    do_reset(8'd1, 8'd0, 4'b1010);
    repeat (50) @(negedge clk);
    // sync restart at several phases of the counters
    for (int s = 1; s < 14; s += 3) begin
      repeat (s) @(negedge clk);
      sync_i = 1;
      @(negedge clk);
      sync_i = 0;
      repeat (30) @(negedge clk);
    end
    // back-to-back sync
    sync_i = 1;
    repeat (3) @(negedge clk);
    sync_i = 0;
    repeat (30) @(negedge clk);
    // mains ratio and phase sweep
    mains_case(1, 8'd0);
    mains_case(2, 8'd0);
    mains_case(5, 8'd0);
    mains_case(1, 8'd1);
    mains_case(2, 8'd5);
    mains_case(3, 8'd6);
    mains_case(1, 8'd255);
    mains_case(0, 8'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule